// File: doc/BRIEF.md
# Single-Line Interrupt Trigger Controller

This block watches one external interrupt line and turns its activity into a latched pending flag. Software picks one of four trigger modes: active-low level, falling edge, active-high level or rising edge. The raw line first passes through a flop synchronizer. The detector then raises a one-cycle set request whenever the selected condition holds, and a pending flag captures that request. The block drives `irq_out` to a parent interrupt controller while the flag is set and the line is enabled.

Software reaches the block through a plain 32-bit word register port with one select, one write strobe, an address and write data. Read data is registered. It appears on `bus_rdata` the cycle after a read select and holds until the next read. The port has no handshake: every select completes in one cycle, so there is no back-pressure. There are three registers: trigger control, pending and enable. A build-time parameter picks one of two address maps for them. An interrupt handler acknowledges an event by writing 1 to the pending bit. In level modes the flag keeps being set while the line holds its active level, so the acknowledge takes effect only once the source has been serviced.

Top module: `irq_trig_ctl`

## Requirements
- R1: After reset, the trigger field is 0 (active-low level), the enable bit is 0, the pending flag is 0, `irq_out` is 0 and `bus_rdata` is 0. The synchronizer resets to the idle-high value, so a line held high through reset raises no event.
- R2: The control register keeps all 32 written bits and reads them back. Bits 1:0 form the trigger field. A read-modify-write that replaces only bits 1:0 leaves the other bits intact.
- R3: A change on `irq_in` passes through two synchronizer flops. The pending flag, and so `irq_out` when enabled, changes at the third rising clock edge after the change is driven.
- R4: Trigger code 3 (rising edge): a 0-to-1 transition of the synchronized line sets the pending flag. The flag stays set after the line falls again. A steady line or a 1-to-0 transition sets nothing.
- R5: Trigger code 1 (falling edge): a 1-to-0 transition sets the pending flag. A 0-to-1 transition sets nothing.
- R6: Trigger code 2 (high level): the pending flag is set on every cycle the synchronized line is 1. An acknowledge issued while the line is high leaves the flag set.
- R7: Trigger code 0 (low level): the pending flag is set on every cycle the synchronized line is 0.
- R8: Writing a word with bit 0 = 1 to the pending register clears the flag when no set request is present. Writing bit 0 = 0 has no effect. The pending register reads as the flag in bit 0 and zero above it.
- R9: A set request and an acknowledge in the same cycle leave the pending flag set.
- R10: `irq_out` is 1 exactly when the pending flag and the enable bit (bit 0 of the enable register) are both 1. The enable register reads as that bit in bit 0 and zero above it.
- R11: With `LAYOUT_B = 0`, control, pending and enable sit at byte offsets 0x00, 0x04 and 0x08. With `LAYOUT_B = 1` they sit at 0x0C, 0x10 and 0x40. Any other address reads zero and ignores writes.
- R12: `bus_rdata` loads the addressed register on the clock edge where `bus_sel` = 1 and `bus_we` = 0, and it holds its value on every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 1 | External interrupt line, asynchronous |
| bus_sel | input | 1 | Register access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_out | output | 1 | Interrupt request to the parent controller |

## Verification
The bench builds two instances that share the interrupt line. The main instance uses `LAYOUT_B = 0` and is exercised in all four trigger modes. The second uses `LAYOUT_B = 1`, which brings the alternate offsets (0x0C, 0x10, 0x40) within reach, along with the check that an offset valid only in the other map reads zero. Both keep the default two-stage synchronizer, so the three-edge input latency is measured against a known count.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW_LVL  = 2'd0,
    TRIG_FALL     = 2'd1,
    TRIG_HIGH_LVL = 2'd2,
    TRIG_RISE     = 2'd3
  } trig_mode_e;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_PEND = 2'd1,
    REG_EN   = 2'd2
  } reg_id_e;

  // Byte offset of a register in the selected address map
  function automatic logic [7:0] reg_off(input logic lay_b, input reg_id_e id);
    logic [7:0] off;
    case (id)
      REG_CTRL: off = lay_b ? 8'h0C : 8'h00;
      REG_PEND: off = lay_b ? 8'h10 : 8'h04;
      default:  off = lay_b ? 8'h40 : 8'h08;
    endcase
    return off;
  endfunction

  function automatic logic is_edge_mode(input trig_mode_e m);
    return (m == TRIG_FALL) || (m == TRIG_RISE);
  endfunction

endpackage

// File: rtl/irq_line_sync.sv
module irq_line_sync #(
  parameter int   STAGES   = 2,
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_sync
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= IDLE_VAL;
    else        chain_q[0] <= line_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q[g] <= IDLE_VAL;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  assign line_sync = chain_q[STAGES-1];
endmodule

// File: rtl/irq_evt_detect.sv
module irq_evt_detect
  import irq_trig_pkg::*;
#(
  parameter logic IDLE_VAL = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  trig_mode_e mode,
  input  logic       line_sync,
  output logic       set_evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= IDLE_VAL;
    else        prev_q <= line_sync;
  end

  always_comb begin
    case (mode)
      TRIG_LOW_LVL:  set_evt = ~line_sync;
      TRIG_FALL:     set_evt = prev_q & ~line_sync;
      TRIG_HIGH_LVL: set_evt = line_sync;
      default:       set_evt = ~prev_q & line_sync;
    endcase
  end

  // R4/R5: an edge is one transition, so two set requests in a row are impossible
  assert_edge_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge_mode(mode) && set_evt) ##1 $stable(mode) |-> !set_evt);
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic ack,
  output logic pend_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (set_evt) pend_q <= 1'b1;
    else if (ack)     pend_q <= 1'b0;
  end

  assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> pend_q);
  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set_evt) |=> !pend_q);
  assert_pend_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !ack) |=> pend_q);
endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
  import irq_trig_pkg::*;
#(
  parameter int   ADDR_W   = 8,
  parameter int   DATA_W   = 32,
  parameter logic LAYOUT_B = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              pend_q,
  output logic              ack,
  output trig_mode_e        mode,
  output logic              en_q
);
  localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(reg_off(LAYOUT_B, REG_CTRL));
  localparam logic [ADDR_W-1:0] OFF_PEND = ADDR_W'(reg_off(LAYOUT_B, REG_PEND));
  localparam logic [ADDR_W-1:0] OFF_EN   = ADDR_W'(reg_off(LAYOUT_B, REG_EN));

  logic [DATA_W-1:0] ctrl_q;
  logic [DATA_W-1:0] rdata_d;
  logic hit_ctrl, hit_pend, hit_en, wr, rd;

  assign hit_ctrl = (bus_addr == OFF_CTRL);
  assign hit_pend = (bus_addr == OFF_PEND);
  assign hit_en   = (bus_addr == OFF_EN);
  assign wr       = bus_sel & bus_we;
  assign rd       = bus_sel & ~bus_we;
  assign ack      = wr & hit_pend & bus_wdata[0];
  assign mode     = trig_mode_e'(ctrl_q[1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= 1'b0;
    end else if (wr) begin
      if (hit_ctrl) ctrl_q <= bus_wdata;
      if (hit_en)   en_q   <= bus_wdata[0];
    end
  end

  always_comb begin
    rdata_d = '0;
    if (hit_ctrl)      rdata_d = ctrl_q;
    else if (hit_pend) rdata_d[0] = pend_q;
    else if (hit_en)   rdata_d[0] = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  bus_rdata <= '0;
    else if (rd) bus_rdata <= rdata_d;
  end

  assert_en_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_en) |=> (en_q == $past(bus_wdata[0])));
  assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(bus_rdata));
  assert_ctrl_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && hit_ctrl) |=> $stable(ctrl_q));
endmodule

// File: rtl/irq_trig_ctl.sv
module irq_trig_ctl
  import irq_trig_pkg::*;
#(
  parameter int   ADDR_W      = 8,
  parameter int   DATA_W      = 32,
  parameter logic LAYOUT_B    = 1'b0,
  parameter int   SYNC_STAGES = 2,
  parameter logic SYNC_IDLE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_in,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  logic       sync_q, set_evt, ack, pend_q, en_q;
  trig_mode_e mode;

  irq_line_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(SYNC_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(irq_in), .line_sync(sync_q));

  irq_evt_detect #(.IDLE_VAL(SYNC_IDLE)) u_det (
    .clk(clk), .rst_n(rst_n), .mode(mode), .line_sync(sync_q), .set_evt(set_evt));

  irq_pend_latch u_pend (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .ack(ack), .pend_q(pend_q));

  irq_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAYOUT_B(LAYOUT_B)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pend_q(pend_q), .ack(ack), .mode(mode), .en_q(en_q));

  assign irq_out = pend_q & en_q;

  assert_high_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_HIGH_LVL && sync_q) |=> pend_q);
  assert_low_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TRIG_LOW_LVL && !sync_q) |=> pend_q);
endmodule

// File: tb/test_irq_trig_ctl.sv
`timescale 1ns/1ps
module test_irq_trig_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_in = 1'b1;
  logic        sel = 1'b0, we = 1'b0, sel_b = 1'b0, we_b = 1'b0;
  logic [7:0]  addr = '0, addr_b = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata_b;
  logic        irq_out, irq_out_b;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  irq_trig_ctl #(.LAYOUT_B(1'b0)) i_irq_trig_ctl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(sel), .bus_we(we),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_out(irq_out));

  irq_trig_ctl #(.LAYOUT_B(1'b1)) i_irq_trig_ctl_b (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_sel(sel_b), .bus_we(we_b),
    .bus_addr(addr_b), .bus_wdata(wdata), .bus_rdata(rdata_b), .irq_out(irq_out_b));

  // {mode[1:0], start level, end level, expected pending}
  localparam logic [4:0] VEC [12] = '{
    {2'd3, 1'b0, 1'b1, 1'b1}, {2'd3, 1'b1, 1'b0, 1'b0}, {2'd3, 1'b1, 1'b1, 1'b0},
    {2'd1, 1'b1, 1'b0, 1'b1}, {2'd1, 1'b0, 1'b1, 1'b0}, {2'd1, 1'b0, 1'b0, 1'b0},
    {2'd2, 1'b0, 1'b1, 1'b1}, {2'd2, 1'b1, 1'b0, 1'b1}, {2'd2, 1'b0, 1'b0, 1'b0},
    {2'd0, 1'b1, 1'b0, 1'b1}, {2'd0, 1'b1, 1'b1, 1'b0}, {2'd0, 1'b0, 1'b1, 1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit b, input logic [7:0] a, input logic [31:0] d);
    if (b) begin sel_b = 1'b1; we_b = 1'b1; addr_b = a; end
    else   begin sel = 1'b1;   we = 1'b1;   addr = a;   end
    wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0; sel_b = 1'b0; we_b = 1'b0;
  endtask

  task automatic rd(input bit b, input logic [7:0] a, output logic [31:0] d);
    if (b) begin sel_b = 1'b1; we_b = 1'b0; addr_b = a; end
    else   begin sel = 1'b1;   we = 1'b0;   addr = a;   end
    @(negedge clk);
    d = b ? rdata_b : rdata;
    sel = 1'b0; sel_b = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    logic [31:0] held;
    cyc(4);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state, idle-high line raises nothing in low-level mode
    chk("R1 irq_out", {31'b0, irq_out}, 32'h0);
    chk("R1 rdata", rdata, 32'h0);
    rd(1'b0, 8'h00, v); chk("R1 ctrl", v, 32'h0);
    rd(1'b0, 8'h08, v); chk("R1 enable", v, 32'h0);
    cyc(5);
    rd(1'b0, 8'h04, v); chk("R1 pending", v, 32'h0);

    // R2 full-width control and read-modify-write of the trigger field
    wr(1'b0, 8'h00, 32'hDEADBEEF);
    rd(1'b0, 8'h00, v); chk("R2 ctrl readback", v, 32'hDEADBEEF);
    v = (v & ~32'h3) | 32'h2;
    wr(1'b0, 8'h00, v);
    rd(1'b0, 8'h00, v); chk("R2 rmw", v, 32'hDEADBEEE);

    // R10 unused enable bits read zero
    wr(1'b0, 8'h08, 32'hFFFFFFFF);
    rd(1'b0, 8'h08, v); chk("R10 enable read", v, 32'h1);

    // R4 R5 R6 R7 table walk with enable set
    for (int i = 0; i < 12; i++) begin
      wr(1'b0, 8'h00, {30'b0, VEC[i][4:3]});
      irq_in = VEC[i][2];
      cyc(5);
      wr(1'b0, 8'h04, 32'h1);
      cyc(1);
      irq_in = VEC[i][1];
      cyc(5);
      chk($sformatf("R4-7 vec%0d mode%0d irq_out (R4 R5 R6 R7)", i, VEC[i][4:3]),
          {31'b0, irq_out}, {31'b0, VEC[i][0]});
      rd(1'b0, 8'h04, v);
      chk($sformatf("vec%0d pending (R4 R5 R6 R7)", i), v, {31'b0, VEC[i][0]});
    end

    // R3 latency through the synchronizer, rising mode
    wr(1'b0, 8'h00, 32'h3);
    irq_in = 1'b0;
    cyc(5);
    wr(1'b0, 8'h04, 32'h1);
    irq_in = 1'b1;
    cyc(2);
    chk("R3 not yet after two edges", {31'b0, irq_out}, 32'h0);
    cyc(1);
    chk("R3 set after third edge", {31'b0, irq_out}, 32'h1);

    // R8 writing zero leaves flag, writing one clears
    wr(1'b0, 8'h04, 32'h0);
    chk("R8 zero write no effect", {31'b0, irq_out}, 32'h1);
    rd(1'b0, 8'h04, v); chk("R8 pending kept", v, 32'h1);
    wr(1'b0, 8'h04, 32'h1);
    rd(1'b0, 8'h04, v); chk("R8 ack clears", v, 32'h0);

    // R9 edge and acknowledge in the same cycle
    irq_in = 1'b0;
    cyc(5);
    irq_in = 1'b1;
    cyc(2);
    wr(1'b0, 8'h04, 32'h1);
    rd(1'b0, 8'h04, v); chk("R9 set wins over ack", v, 32'h1);

    // R10 enable masks the output
    wr(1'b0, 8'h08, 32'h0);
    chk("R10 masked", {31'b0, irq_out}, 32'h0);
    wr(1'b0, 8'h08, 32'h1);
    chk("R10 unmasked", {31'b0, irq_out}, 32'h1);

    // R12 read data holds between reads
    rd(1'b0, 8'h00, held);
    wr(1'b0, 8'h00, 32'h7);
    cyc(3);
    chk("R12 rdata holds", rdata, held);
    wr(1'b0, 8'h00, 32'h3);

    // R11 layout A: unmapped address
    wr(1'b0, 8'h20, 32'h5);
    rd(1'b0, 8'h00, v); chk("R11 unmapped write ignored", v, 32'h3);
    rd(1'b0, 8'h20, v); chk("R11 unmapped reads zero", v, 32'h0);

    // R11 layout B offsets (line is high: high-level mode sets pending)
    wr(1'b1, 8'h0C, 32'h2);
    rd(1'b1, 8'h0C, v); chk("R11 B ctrl", v, 32'h2);
    wr(1'b1, 8'h40, 32'h1);
    rd(1'b1, 8'h40, v); chk("R11 B enable", v, 32'h1);
    rd(1'b1, 8'h08, v); chk("R11 B offset 0x08 unmapped", v, 32'h0);
    rd(1'b1, 8'h10, v); chk("R11 B pending", v, 32'h1);
    chk("R11 B irq_out", {31'b0, irq_out_b}, 32'h1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule